// File: doc/BRIEF.md
# Local Alignment Scoring Cell

This block is one cell of a linear systolic chain that scores local alignments between two nucleotide strings. Each cell holds one character of the query string. The subject string moves through the chain one character per clock. In each cycle a cell fills one entry of the local-alignment score table. It works from three scores: its own score from the previous cycle (the entry above), the left neighbour's current score (the entry to the left), and the left neighbour's score from one cycle earlier (the diagonal entry).

A match adds +2 and a mismatch adds -1 to the diagonal score. A gap in either direction costs a flat 1. A negative score is replaced by zero. The two gap candidates carry the same penalty, so the cell first takes the larger of the upper and left scores and subtracts the penalty once. It then compares that value with the diagonal candidate. The score register is followed by a second register that holds the previous score. The next cell reads that register as its diagonal input, so no cell needs more than two compare stages per cycle. A valid flag travels with the subject character. When a cell has no valid character, it holds its score at zero.

For the first cell of a chain, tie the left and diagonal score inputs to zero. Each later cell takes its inputs from the previous cell's subject, valid, score and delayed-score outputs.

Top module: `sw_cell`

## Requirements
- R1: The query register changes only on an edge where `load_q` is high, and then takes `q_sym`. Scoring on that same edge uses the value the register held before the edge.
- R2: Characters are coded A=00, C=01, G=10, T=11. When the stored query equals `s_sym_in` and the diagonal route wins, the new score is `h_diag_in` + 2.
- R3: When the stored query differs from `s_sym_in` and the diagonal route wins, the new score is `h_diag_in` - 1.
- R4: The gap candidate is the larger of the cell's own previous score and `h_left_in`, minus 1.
- R5: On an edge with `s_valid_in` high, `h_out` becomes the larger of the diagonal candidate and the gap candidate.
- R6: A result below zero is stored as zero, so `h_out` is never negative.
- R7: On an edge with `s_valid_in` low, `h_out` becomes zero and no score input affects it.
- R8: `s_sym_out` and `s_valid_out` repeat `s_sym_in` and `s_valid_in` one cycle later.
- R9: `h_dly_out` equals the value `h_out` had in the previous cycle.
- R10: A synchronous reset sets `h_out`, `h_dly_out`, `s_valid_out`, `s_sym_out` and the query register to zero.
- R11: Scores are 20-bit two's complement values. Scores up to 2^19-3 are handled without wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| load_q | input | 1 | Query capture strobe |
| q_sym | input | 2 | Query character to capture |
| s_sym_in | input | 2 | Subject character from the previous cell |
| s_valid_in | input | 1 | Subject character is valid |
| h_left_in | input | 20 | Previous cell's current score |
| h_diag_in | input | 20 | Previous cell's score from one cycle earlier |
| s_sym_out | output | 2 | Subject character to the next cell |
| s_valid_out | output | 1 | Valid flag to the next cell |
| h_out | output | 20 | This cell's score |
| h_dly_out | output | 20 | This cell's score from the previous cycle |

## Verification
A query load can fall on the same edge as a valid subject character. When that happens, the score must come from the old query and the new query must take effect only on the next edge. The bench provokes this by loading a character that reverses the match outcome while a subject character is valid. It then checks two consecutive scores against values computed for the old query and then for the new one. The bench also sweeps every query and subject pair over a grid of left and diagonal scores. This makes the gap route and the diagonal route tie or win in turn, and lets the zero floor cut in where both candidates go negative.

// File: rtl/sw_cell_pkg.sv
package sw_cell_pkg;
  localparam int NT_W = 2;
  typedef enum logic [NT_W-1:0] {NT_A = 2'b00, NT_C = 2'b01, NT_G = 2'b10, NT_T = 2'b11} nt_e;
endpackage

// File: rtl/sw_query_reg.sv
module sw_query_reg #(
  parameter int SYM_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [SYM_W-1:0] d,
  output logic [SYM_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end

  AST_QUERY_HOLD: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(q)); // R1
  AST_QUERY_TAKE: assert property (@(posedge clk) disable iff (rst)
    load |=> q == $past(d)); // R1
endmodule

// File: rtl/sw_score_core.sv
module sw_score_core #(
  parameter int SYM_W    = 2,
  parameter int SCORE_W  = 20,
  parameter int MATCH    = 2,
  parameter int MISMATCH = -1,
  parameter int GAP      = 1
) (
  input  logic [SYM_W-1:0]   q_sym,
  input  logic [SYM_W-1:0]   s_sym,
  input  logic [SCORE_W-1:0] h_up,
  input  logic [SCORE_W-1:0] h_left,
  input  logic [SCORE_W-1:0] h_diag,
  output logic [SCORE_W-1:0] h_next,
  output logic               ev_match,
  output logic               ev_gap_wins,
  output logic               ev_floored
);
  localparam int EXT_W = SCORE_W + 2;
  typedef logic signed [EXT_W-1:0] ext_t;

  function automatic ext_t f_ext(input logic [SCORE_W-1:0] x);
    return ext_t'($signed(x));
  endfunction

  function automatic ext_t f_sub(input logic [SYM_W-1:0] a, input logic [SYM_W-1:0] b);
    return (a == b) ? ext_t'(MATCH) : ext_t'(MISMATCH);
  endfunction

  function automatic ext_t f_gap(input ext_t up, input ext_t left);
    return ((up > left) ? up : left) - ext_t'(GAP);
  endfunction

  function automatic ext_t f_floor(input ext_t x);
    return x[EXT_W-1] ? '0 : x;
  endfunction

  ext_t cand_diag, cand_gap, best;

  // stage one: the two candidates are formed in parallel
  always_comb begin
    cand_diag = f_ext(h_diag) + f_sub(q_sym, s_sym);
    cand_gap  = f_gap(f_ext(h_up), f_ext(h_left));
  end

  // stage two: a single compare, then the sign-based floor
  always_comb begin
    best   = (cand_gap > cand_diag) ? cand_gap : cand_diag;
    h_next = SCORE_W'(f_floor(best));
  end

  assign ev_match    = (q_sym == s_sym);
  assign ev_gap_wins = cand_gap > cand_diag;
  assign ev_floored  = best[EXT_W-1];

  always_comb begin
    AST_NEXT_NONNEG: assert (!h_next[SCORE_W-1] || ^h_next === 1'bx); // R6
  end
endmodule

// File: rtl/sw_cell_regs.sv
module sw_cell_regs #(
  parameter int SYM_W   = 2,
  parameter int SCORE_W = 20
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               v_in,
  input  logic [SYM_W-1:0]   s_in,
  input  logic [SCORE_W-1:0] h_next,
  output logic               v_q,
  output logic [SYM_W-1:0]   s_q,
  output logic [SCORE_W-1:0] h_q,
  output logic [SCORE_W-1:0] h_dly_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      v_q     <= 1'b0;
      s_q     <= '0;
      h_q     <= '0;
      h_dly_q <= '0;
    end else begin
      v_q     <= v_in;
      s_q     <= s_in;
      h_q     <= v_in ? h_next : '0;
      h_dly_q <= h_q;
    end
  end

  AST_FORWARD: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (s_q == $past(s_in)) && (v_q == $past(v_in))); // R8
  AST_DLY_COPY: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> h_dly_q == $past(h_q)); // R9
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !v_in |=> h_q == '0); // R7
endmodule

// File: rtl/sw_cell.sv
module sw_cell #(
  parameter int SYM_W    = sw_cell_pkg::NT_W,
  parameter int SCORE_W  = 20,
  parameter int MATCH    = 2,
  parameter int MISMATCH = -1,
  parameter int GAP      = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load_q,
  input  logic [SYM_W-1:0]   q_sym,
  input  logic [SYM_W-1:0]   s_sym_in,
  input  logic               s_valid_in,
  input  logic [SCORE_W-1:0] h_left_in,
  input  logic [SCORE_W-1:0] h_diag_in,
  output logic [SYM_W-1:0]   s_sym_out,
  output logic               s_valid_out,
  output logic [SCORE_W-1:0] h_out,
  output logic [SCORE_W-1:0] h_dly_out
);
  logic [SYM_W-1:0]   q_held;
  logic [SCORE_W-1:0] h_next;
  logic               ev_match, ev_gap_wins, ev_floored;

  sw_query_reg #(.SYM_W(SYM_W)) u_query (
    .clk(clk), .rst(rst), .load(load_q), .d(q_sym), .q(q_held)
  );

  sw_score_core #(
    .SYM_W(SYM_W), .SCORE_W(SCORE_W), .MATCH(MATCH),
    .MISMATCH(MISMATCH), .GAP(GAP)
  ) u_core (
    .q_sym(q_held), .s_sym(s_sym_in), .h_up(h_out), .h_left(h_left_in),
    .h_diag(h_diag_in), .h_next(h_next), .ev_match(ev_match),
    .ev_gap_wins(ev_gap_wins), .ev_floored(ev_floored)
  );

  sw_cell_regs #(.SYM_W(SYM_W), .SCORE_W(SCORE_W)) u_regs (
    .clk(clk), .rst(rst), .v_in(s_valid_in), .s_in(s_sym_in), .h_next(h_next),
    .v_q(s_valid_out), .s_q(s_sym_out), .h_q(h_out), .h_dly_q(h_dly_out)
  );

  AST_NONNEG: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> !h_out[SCORE_W-1]); // R6
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
    s_valid_in |=> $signed(h_out) >= $signed($past(h_out)) - GAP); // R4
  AST_MATCH_DIAG: assert property (@(posedge clk) disable iff (rst)
    (s_valid_in && ev_match && !ev_gap_wins && !ev_floored) |=>
      $signed(h_out) == $signed($past(h_diag_in)) + MATCH); // R2
  AST_FLOOR_ZERO: assert property (@(posedge clk) disable iff (rst)
    (s_valid_in && ev_floored) |=> h_out == '0); // R6
endmodule

// File: tb/sw_cell_tb.sv
`timescale 1ns/1ps
module sw_cell_tb;
  logic clk = 1'b0;
  logic rst, load_q, s_valid_in;
  logic [1:0] q_sym, s_sym_in, s_sym_out;
  logic s_valid_out;
  logic [19:0] h_left_in, h_diag_in, h_out, h_dly_out;

  int tests = 0, fails = 0;
  bit finished = 0;
  int m_h, m_dly, m_q, m_s, m_v;

  always #4 clk = ~clk;

  sw_cell u_dut (
    .clk(clk), .rst(rst), .load_q(load_q), .q_sym(q_sym), .s_sym_in(s_sym_in),
    .s_valid_in(s_valid_in), .h_left_in(h_left_in), .h_diag_in(h_diag_in),
    .s_sym_out(s_sym_out), .s_valid_out(s_valid_out), .h_out(h_out),
    .h_dly_out(h_dly_out)
  );

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic string expect_score(input int q, input int s, input int up,
                                         input int left, input int dg, output int res);
    int cands[3];
    int top;
    cands[0] = dg + ((q == s) ? 2 : -1);
    cands[1] = up - 1;
    cands[2] = left - 1;
    top = cands[0];
    for (int k = 1; k < 3; k++) if (cands[k] > top) top = cands[k];
    res = (top < 0) ? 0 : top;
    if (top < 0) return "R6";
    if (top == cands[0] && cands[0] >= cands[1] && cands[0] >= cands[2])
      return (q == s) ? "R2" : "R3";
    return "R4";
  endfunction

  task automatic step(input bit ld, input int qv, input int sv, input bit vv,
                      input int left, input int dg);
    int nh;
    string tag;
    load_q = ld; q_sym = 2'(qv); s_sym_in = 2'(sv); s_valid_in = vv;
    h_left_in = 20'(left); h_diag_in = 20'(dg);
    if (vv) tag = expect_score(m_q, sv, m_h, left, dg, nh);
    else begin nh = 0; tag = "R7"; end
    @(posedge clk);
    m_dly = m_h; m_h = nh; m_s = sv; m_v = vv;
    if (ld) m_q = qv;
    @(negedge clk);
    chk({tag, "/R5 score"}, $signed(h_out), m_h);
    chk("R9 delayed score", $signed(h_dly_out), m_dly);
    chk("R8 forwarded subject", {29'd0, s_valid_out, s_sym_out}, m_v * 4 + m_s);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    load_q = 0; q_sym = 0; s_sym_in = 0; s_valid_in = 0; h_left_in = 0; h_diag_in = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_h = 0; m_dly = 0; m_q = 0; m_s = 0; m_v = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int lefts[4];
    int diags[3];
    lefts = '{0, 1, 3, 6};
    diags = '{0, 2, 5};
    // R10: reset state after garbage
    rst = 1'b0;
    load_q = 1; q_sym = 3; s_sym_in = 2; s_valid_in = 1; h_left_in = 9; h_diag_in = 9;
    @(posedge clk); @(negedge clk);
    do_reset();
    chk("R10 score after reset", $signed(h_out), 0);
    chk("R10 delayed after reset", $signed(h_dly_out), 0);
    chk("R10 valid/subject after reset", {29'd0, s_valid_out, s_sym_out}, 0);
    // R10: query register reset to A: subject A with diag 4 must match
    step(0, 3, 0, 1, 0, 4);
    chk("R10 query reset to A", $signed(h_out), 6);
    step(0, 0, 0, 0, 0, 0);

    // exhaustive sweep: R1..R6
    for (int q = 0; q < 4; q++) begin
      step(1, q, 0, 0, 0, 0);
      for (int s = 0; s < 4; s++)
        for (int a = 0; a < 4; a++)
          for (int b = 0; b < 3; b++)
            step(0, (q + 1) % 4, s, 1, lefts[a], diags[b]);
      step(0, 0, 1, 0, 7, 7);   // R7: idle ignores score inputs
    end

    // R1: load and valid subject on the same edge
    step(1, 2, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    step(1, 1, 1, 1, 0, 10);   // old query G vs C: mismatch -> 9
    chk("R1 old query used on load edge", $signed(h_out), 9);
    step(0, 3, 1, 1, 0, 10);   // new query C vs C: match -> 12
    chk("R1 new query after load", $signed(h_out), 12);

    // R11: large scores without wrap
    step(0, 0, 1, 1, 0, 524285);
    chk("R11 large match", $signed(h_out), 524287);
    step(0, 0, 2, 1, 300000, 400000);
    chk("R11 large gap route", $signed(h_out), 524286);

    // R6: floor with everything at zero and a mismatch
    step(0, 0, 0, 0, 0, 0);
    step(0, 0, 3, 1, 0, 0);
    chk("R6 floor on mismatch", $signed(h_out), 0);

    // R10: reset mid-run
    step(0, 0, 1, 1, 50, 50);
    do_reset();
    chk("R10 mid-run reset", $signed(h_out), 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule